// File: doc/BRIEF.md
# Preamble Lock and Error Monitor

This block sits behind the framing stage of a digital audio interface receiver and turns two event streams into receiver status. One stream is a strobe for each block/subframe preamble. The other is a strobe at the end of each subframe, which carries that subframe's parity result. From these the block derives a lock flag and an error flag. It then times a settling window before it declares the channel-status flags (copy, emphasis, sample rate) trustworthy.

Lock requires two preambles in a row, each arriving within a timeout window of the one before it. The error flag is raised in three cases: lock is missing, parity has failed on eight subframes in a row, or the receiver is halted. The receiver is halted when the run input is low, when stop is high, or when no input signal is present. While an error is present, the channel-status flags presented downstream are held low. They pass through only after a parameterised number of reference ticks has elapsed with the error flag continuously low. Every new error restarts that count.

Top module: `preamble_lock_monitor`

## Requirements
- R1: With no halt, `lock_o` goes high after the clock edge at which a second preamble strobe is sampled, provided it came no more than PREAM_TIMEOUT clocks after the previous preamble.
- R2: Whenever `run_i` is low, `stop_i` is high or `no_signal_i` is high, `lock_o` is low and `error_o` is high in the same cycle. The preamble streak and the parity-failure count are cleared at the next edge.
- R3: If PREAM_TIMEOUT clock edges pass after a preamble with no new preamble sampled, the streak is cleared. A preamble period of PREAM_TIMEOUT clocks keeps lock, and a period of PREAM_TIMEOUT+1 loses it.
- R4: `error_o` is high whenever `lock_o` is low.
- R5: `error_o` goes high after the edge that samples the PAR_FAIL_LIMIT-th consecutive subframe end with `parity_ok_i` low (limit 8). PAR_FAIL_LIMIT-1 failures do not raise it, and one passing subframe clears the count.
- R6: While `error_o` is high, `cs_valid_o` is low and every bit of `cs_flags_o` is 0.
- R7: `cs_valid_o` rises after the edge that samples the SETTLE_TICKS-th `ref_tick_i` pulse since `error_o` last was high. Any cycle with `error_o` high restarts the count from zero.
- R8: While `cs_valid_o` is high, `cs_flags_o` equals `cs_flags_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| run_i | input | 1 | System run; low forces the halted state |
| stop_i | input | 1 | High stops the receiver (halted state) |
| no_signal_i | input | 1 | High when no input signal is present |
| pream_i | input | 1 | One-cycle strobe per detected preamble |
| sf_end_i | input | 1 | One-cycle strobe at the end of each subframe |
| parity_ok_i | input | 1 | Parity result, valid with `sf_end_i` (1 = pass) |
| ref_tick_i | input | 1 | Reference time tick for the settling count |
| cs_flags_i | input | CS_W | Decoded channel-status flags |
| lock_o | output | 1 | Receiver locked |
| error_o | output | 1 | Receiver error |
| cs_valid_o | output | 1 | Channel-status flags valid |
| cs_flags_o | output | CS_W | Gated channel-status flags |

## Verification
The halt conditions act on `lock_o` and `error_o` in the same cycle, with no register in between. Preamble and parity strobes take effect one edge after they are sampled, and `cs_valid_o` rises one edge after the final qualifying reference tick. A behavioural model in the bench advances its state at each rising edge from the inputs held over that edge. It is compared with every output at the following falling edge, before new inputs are applied, so each result is checked in exactly the cycle it is due. The directed phases probe the boundaries: preamble periods at and just over the timeout, seven versus eight parity failures, and errors injected partway through the settling window.

// File: rtl/plm_pkg.sv
package plm_pkg;
  typedef enum logic [1:0] {
    STRK_NONE = 2'd0,
    STRK_ONE  = 2'd1,
    STRK_LOCK = 2'd2
  } streak_e;
endpackage

// File: rtl/plm_pream_tracker.sv
module plm_pream_tracker import plm_pkg::*; #(
  parameter int unsigned PREAM_TIMEOUT = 3200
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic pream_i,
  output logic locked_o
);
  localparam int unsigned GW = $clog2(PREAM_TIMEOUT + 1);
  localparam logic [GW-1:0] GAP_LAST = GW'(PREAM_TIMEOUT - 1);

  streak_e       streak_q;
  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      streak_q <= STRK_NONE;
      gap_q    <= '0;
    end else if (halt_i) begin
      streak_q <= STRK_NONE;
      gap_q    <= '0;
    end else if (pream_i) begin
      gap_q    <= '0;
      streak_q <= (streak_q == STRK_NONE) ? STRK_ONE : STRK_LOCK;
    end else if (gap_q == GAP_LAST) begin
      // window expired without a preamble
      gap_q    <= '0;
      streak_q <= STRK_NONE;
    end else begin
      gap_q <= gap_q + 1'b1;
    end
  end

  assign locked_o = (streak_q == STRK_LOCK);
endmodule

// File: rtl/plm_parity_watch.sv
module plm_parity_watch #(
  parameter int unsigned PAR_FAIL_LIMIT = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic halt_i,
  input  logic sf_end_i,
  input  logic parity_ok_i,
  output logic fail_o
);
  localparam int unsigned FW = $clog2(PAR_FAIL_LIMIT + 1);
  localparam logic [FW-1:0] FAIL_MAX = FW'(PAR_FAIL_LIMIT);

  logic [FW-1:0] fail_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fail_q <= '0;
    end else if (halt_i) begin
      fail_q <= '0;
    end else if (sf_end_i) begin
      if (parity_ok_i)            fail_q <= '0;
      else if (fail_q != FAIL_MAX) fail_q <= fail_q + 1'b1;
    end
  end

  assign fail_o = (fail_q == FAIL_MAX);
endmodule

// File: rtl/plm_settle_timer.sv
module plm_settle_timer #(
  parameter int unsigned SETTLE_TICKS = 6000
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic err_i,
  input  logic tick_i,
  output logic valid_o
);
  localparam int unsigned SW = $clog2(SETTLE_TICKS + 1);
  localparam logic [SW-1:0] TICK_LAST = SW'(SETTLE_TICKS - 1);

  logic [SW-1:0] cnt_q;
  logic          valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (err_i) begin
      cnt_q   <= '0;
      valid_q <= 1'b0;
    end else if (!valid_q && tick_i) begin
      if (cnt_q == TICK_LAST) valid_q <= 1'b1;
      else                    cnt_q   <= cnt_q + 1'b1;
    end
  end

  assign valid_o = valid_q;
endmodule

// File: rtl/preamble_lock_monitor.sv
module preamble_lock_monitor #(
  parameter int unsigned PREAM_TIMEOUT  = 3200,
  parameter int unsigned PAR_FAIL_LIMIT = 8,
  parameter int unsigned SETTLE_TICKS   = 6000,
  parameter int unsigned CS_W           = 5
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            run_i,
  input  logic            stop_i,
  input  logic            no_signal_i,
  input  logic            pream_i,
  input  logic            sf_end_i,
  input  logic            parity_ok_i,
  input  logic            ref_tick_i,
  input  logic [CS_W-1:0] cs_flags_i,
  output logic            lock_o,
  output logic            error_o,
  output logic            cs_valid_o,
  output logic [CS_W-1:0] cs_flags_o
);
  logic halt;
  logic locked;
  logic par_fail;
  logic settled;

  assign halt = !run_i || stop_i || no_signal_i;

  plm_pream_tracker #(.PREAM_TIMEOUT(PREAM_TIMEOUT)) u_pream (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .halt_i   (halt),
    .pream_i  (pream_i),
    .locked_o (locked)
  );

  plm_parity_watch #(.PAR_FAIL_LIMIT(PAR_FAIL_LIMIT)) u_par (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .halt_i      (halt),
    .sf_end_i    (sf_end_i),
    .parity_ok_i (parity_ok_i),
    .fail_o      (par_fail)
  );

  assign lock_o  = locked && !halt;
  assign error_o = halt || !locked || par_fail;

  plm_settle_timer #(.SETTLE_TICKS(SETTLE_TICKS)) u_settle (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .err_i   (error_o),
    .tick_i  (ref_tick_i),
    .valid_o (settled)
  );

  assign cs_valid_o = settled && !error_o;

  for (genvar b = 0; b < CS_W; b++) begin : g_gate
    assign cs_flags_o[b] = cs_flags_i[b] && cs_valid_o;
  end
endmodule

// File: rtl/plm_checker.sv
module plm_checker #(
  parameter int unsigned CS_W = 5
) (
  input logic            clk_i,
  input logic            rst_ni,
  input logic            run_i,
  input logic            stop_i,
  input logic            no_signal_i,
  input logic            ref_tick_i,
  input logic [CS_W-1:0] cs_flags_i,
  input logic            lock_o,
  input logic            error_o,
  input logic            cs_valid_o,
  input logic [CS_W-1:0] cs_flags_o
);
  AST_HALT_FORCES_STATUS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!run_i || stop_i || no_signal_i) |-> (!lock_o && error_o)); // R2
  AST_UNLOCK_MEANS_ERROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lock_o |-> error_o); // R4
  AST_ERROR_GATES_CS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    error_o |-> (!cs_valid_o && cs_flags_o == '0)); // R6
  AST_VALID_RISE_ON_TICK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(cs_valid_o) |-> ($past(ref_tick_i) && !$past(error_o))); // R7
  AST_VALID_PASSES_FLAGS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cs_valid_o |-> (cs_flags_o == cs_flags_i)); // R8
endmodule

bind preamble_lock_monitor plm_checker #(.CS_W(CS_W)) u_chk (.*);

// File: tb/preamble_lock_monitor_tb.sv
`timescale 1ns/1ps
module preamble_lock_monitor_tb;
  localparam int TMO = 12;
  localparam int LIM = 8;
  localparam int STK = 10;
  localparam int CW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic run = 1'b0, stop = 1'b0, nosig = 1'b0;
  logic pream = 1'b0, sfe = 1'b0, pok = 1'b1, tick = 1'b0;
  logic [CW-1:0] flags_in = '0;
  logic lock, err, valid;
  logic [CW-1:0] flags_out;

  always #2.5 clk = ~clk;

  preamble_lock_monitor #(.PREAM_TIMEOUT(TMO), .PAR_FAIL_LIMIT(LIM),
                          .SETTLE_TICKS(STK), .CS_W(CW)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .run_i(run), .stop_i(stop),
    .no_signal_i(nosig), .pream_i(pream), .sf_end_i(sfe),
    .parity_ok_i(pok), .ref_tick_i(tick), .cs_flags_i(flags_in),
    .lock_o(lock), .error_o(err), .cs_valid_o(valid), .cs_flags_o(flags_out)
  );

  int checks = 0, errors = 0;
  bit done = 0;
  string cur_req = "R2";
  // reference model state
  int m_gap = 0, m_streak = 0, m_fails = 0, m_scnt = 0;
  bit m_val = 0;
  int cyc = 0;

  function automatic bit m_halt();
    return !run || stop || nosig;
  endfunction
  function automatic bit m_err();
    return m_halt() || m_streak != 2 || m_fails == LIM;
  endfunction

  task automatic check(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic compare_all();
    bit e_err, e_lock, e_val;
    e_err  = m_err();
    e_lock = !m_halt() && m_streak == 2;
    e_val  = m_val && !e_err;
    check(cur_req, "lock_o", int'(lock), int'(e_lock));
    check(cur_req, "error_o", int'(err), int'(e_err));
    check(cur_req, "cs_valid_o", int'(valid), int'(e_val));
    check(cur_req, "cs_flags_o", int'(flags_out), e_val ? int'(flags_in) : 0);
  endtask

  // one clock: inputs applied, model advanced at edge, outputs compared at falling edge
  task automatic step(bit p, bit s, bit ok);
    bit e_now;
    pream = p; sfe = s; pok = ok;
    tick = (cyc % 3 == 0);
    flags_in = CW'($urandom);
    @(posedge clk);
    e_now = m_err();
    if (m_halt()) begin
      m_gap = 0; m_streak = 0; m_fails = 0;
    end else begin
      if (p) begin m_gap = 0; if (m_streak < 2) m_streak++; end
      else if (m_gap == TMO - 1) begin m_gap = 0; m_streak = 0; end
      else m_gap++;
      if (s) m_fails = ok ? 0 : (m_fails < LIM ? m_fails + 1 : m_fails);
    end
    if (e_now) begin m_scnt = 0; m_val = 0; end
    else if (!m_val && tick) begin
      if (m_scnt == STK - 1) m_val = 1; else m_scnt++;
    end
    cyc++;
    @(negedge clk);
    compare_all();
  endtask

  // run n cycles with a preamble every pp cycles and subframe end every sp cycles
  task automatic run_pattern(int n, int pp, int sp, bit ok);
    for (int i = 0; i < n; i++)
      step((i % pp) == pp - 1, (i % sp) == sp - 1, ok);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2", "reset lock_o", int'(lock), 0);
    check("R2", "reset error_o", int'(err), 1);
    check("R6", "reset cs_valid_o", int'(valid), 0);
    rst_n = 1'b1;
    run = 1'b1;
    // R1: lock after the second preamble
    cur_req = "R1";
    run_pattern(6, 6, 3, 1'b1);
    check("R1", "one preamble no lock", int'(lock), 0);
    run_pattern(6, 6, 3, 1'b1);
    check("R1", "lock after second preamble", int'(lock), 1);
    check("R4", "error low when locked", int'(err), 0);
    // R7/R8: settle then pass flags
    cur_req = "R7";
    run_pattern(3 * STK - 4, 6, 3, 1'b1);
    cur_req = "R8";
    run_pattern(12, 6, 3, 1'b1);
    check("R8", "valid after settling", int'(valid), 1);
    // R5: seven failures then a pass, then eight failures
    cur_req = "R5";
    run_pattern((LIM - 1) * 2, 6, 2, 1'b0);
    check("R5", "seven failures no error", int'(err), 0);
    step(1'b0, 1'b1, 1'b1);
    run_pattern((LIM - 1) * 2, 6, 2, 1'b0);
    check("R5", "pass cleared count", int'(err), 0);
    step(1'b0, 1'b1, 1'b0);
    check("R5", "eighth failure error", int'(err), 1);
    cur_req = "R6";
    check("R6", "flags gated", int'(flags_out), 0);
    run_pattern(12, 6, 3, 1'b1);
    // R7: error mid-settle restarts
    cur_req = "R7";
    run_pattern(10, 6, 3, 1'b1);
    run_pattern(4, 6, 2, 1'b0);
    run_pattern(LIM * 2, 6, 2, 1'b0);
    run_pattern(3 * STK + 6, 6, 3, 1'b1);
    check("R7", "valid after restart", int'(valid), 1);
    // R3: period exactly TMO keeps lock, TMO+1 loses it
    cur_req = "R3";
    run_pattern(TMO * 4, TMO, 3, 1'b1);
    check("R3", "period at timeout keeps lock", int'(lock), 1);
    run_pattern(TMO + 1, TMO + 1, 3, 1'b1);
    check("R3", "period over timeout loses lock", int'(lock), 0);
    check("R4", "error when unlocked", int'(err), 1);
    run_pattern(30, 5, 3, 1'b1);
    // R2: each halt source
    cur_req = "R2";
    stop = 1'b1; step(1'b1, 1'b1, 1'b0);
    check("R2", "stop forces error", int'(err), 1);
    stop = 1'b0; run_pattern(12, 5, 3, 1'b1);
    nosig = 1'b1; run_pattern(4, 2, 2, 1'b1);
    check("R2", "no signal forces unlock", int'(lock), 0);
    nosig = 1'b0; run_pattern(12, 5, 3, 1'b1);
    run = 1'b0; run_pattern(4, 2, 2, 1'b1);
    run = 1'b1; run_pattern(3 * STK + 20, 5, 3, 1'b1);
    check("R2", "relock after halt", int'(lock), 1);
    finish_run();
  end
endmodule